// File: doc/BRIEF.md
# Audio Serial Bit and Word Clock Divider

This block turns an incoming audio master clock into the two timing signals a serial audio link needs. The first is a bit clock at one half or one quarter of the master rate. The second is a left/right word clock that is a further division of the bit clock. The block also produces a one-cycle strobe at the start of every left-channel word. All logic runs on the master clock, so both derived clocks are registered, glitch-free data signals in that domain.

One enable starts and stops both derived clocks together. Once started, the block always runs in whole frames. Dropping the enable lets the frame in progress finish, and then both outputs rest low. The two divide-select inputs are captured only at frame boundaries, so the ratios can be rewritten at any moment without producing a short or torn frame.

Top module: `i2s_clk_gen`

## Requirements
- R1: While reset is asserted, and after its release until enable is seen, `sclk`, `lrclk` and `frame_start` are all low.
- R2: `sclk` runs at the master rate divided by 2 when `sclk_div4` is 0 and divided by 4 when it is 1. Each frame starts with `sclk` low, and its first rising edge comes 1 (divide by 2) or 2 (divide by 4) master cycles after the frame-start strobe.
- R3: One `lrclk` period lasts 32, 64 or 128 `sclk` periods for `frame_ratio` values 2'b00, 2'b01 and 2'b10. `lrclk` is low for the first half of the frame and high for the second half.
- R4: `frame_ratio` value 2'b11 gives a frame of 128 `sclk` periods, the same as 2'b10.
- R5: `lrclk` changes only in the master cycle in which `sclk` changes from high to low.
- R6: `frame_start` is high for exactly one master cycle at the start of every frame, and `lrclk` is low in that cycle.
- R7: When `en` is sampled high while the block is idle, `frame_start` goes high in the next cycle and a new frame begins, with `sclk` and `lrclk` low.
- R8: When `en` is dropped mid-frame, the frame runs to its full length. From the end of that frame `sclk` and `lrclk` stay low and `frame_start` stays low until `en` returns.
- R9: A change to `sclk_div4` or `frame_ratio` during a frame leaves that frame unchanged and takes effect from the next frame start.
- R10: While the block is idle, changes on `sclk_div4` and `frame_ratio` leave all outputs low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Audio master clock; all logic runs on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run request shared by both derived clocks |
| sclk_div4 | input | 1 | Bit-clock ratio select: 0 gives /2, 1 gives /4 |
| frame_ratio | input | 2 | Word-clock ratio select: 00 gives /32, 01 gives /64, 10 and 11 give /128 |
| sclk | output | 1 | Serial bit clock |
| lrclk | output | 1 | Left/right word clock: low for left, high for right |
| frame_start | output | 1 | One-cycle strobe at the start of each left word |

## Verification
Every output is a register, so the start strobe is due in the first master cycle after `en` is sampled. The first `sclk` rise is due H cycles later, where H is 1 or 2. A frame lasts 2·H·R cycles for a ratio R, with `lrclk` high for the last H·R of them. The bench drives inputs and samples outputs on falling edges. It measures each frame by counting sampled cycles from one strobe to the next, and checks that count, the number of bit-clock rises, the high-time of the word clock and the first-rise offset against values it computes from H and R. For the stop and reconfiguration cases, it counts cycles from the last strobe to the point where the outputs must be parked or the new ratios must show.

// File: rtl/i2s_clk_pkg.sv
package i2s_clk_pkg;

   typedef enum logic [1:0] {
      FR_BASE = 2'b00,
      FR_X2   = 2'b01,
      FR_X4   = 2'b10,
      FR_RSVD = 2'b11
   } frame_ratio_e;

   // Extra left shift applied to the base frame ratio; the reserved code
   // behaves as the largest ratio.
   function automatic int unsigned ratio_shift(frame_ratio_e sel);
      case (sel)
         FR_BASE: return 0;
         FR_X2:   return 1;
         default: return 2;
      endcase
   endfunction

endpackage

// File: rtl/i2s_sclk_div.sv
module i2s_sclk_div #(
   parameter int unsigned HALF_LO = 1,
   parameter int unsigned HALF_HI = 2
) (
   input  logic mclk,
   input  logic rst_n,
   input  logic run,
   input  logic sel_hi,
   output logic sclk,
   output logic fall_tick
);

   localparam int unsigned CW = (HALF_HI > 1) ? $clog2(HALF_HI) : 1;

   logic [CW-1:0] cnt_q;
   logic          sclk_q;
   logic [CW-1:0] half_m1;
   logic          term;

   assign half_m1   = sel_hi ? CW'(HALF_HI - 1) : CW'(HALF_LO - 1);
   assign term      = (cnt_q == half_m1);
   assign fall_tick = run & term & sclk_q;
   assign sclk      = sclk_q;

   always_ff @(posedge mclk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         sclk_q <= 1'b0;
      end else if (!run) begin
         cnt_q  <= '0;
         sclk_q <= 1'b0;
      end else if (term) begin
         cnt_q  <= '0;
         sclk_q <= ~sclk_q;
      end else begin
         cnt_q  <= cnt_q + 1'b1;
      end
   end

   // R2
   sclk_low_at_start_chk: assert property (@(posedge mclk) disable iff (!rst_n)
      (run && !$past(run)) |-> !sclk_q);

   // R2
   half_hold_chk: assert property (@(posedge mclk) disable iff (!rst_n)
      (run && $past(run) && !$past(term)) |-> $stable(sclk_q));

endmodule

// File: rtl/i2s_frame_div.sv
module i2s_frame_div
   import i2s_clk_pkg::*;
#(
   parameter int unsigned BASE_LOG2 = 5
) (
   input  logic         mclk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         sel_hi_in,
   input  frame_ratio_e ratio_in,
   input  logic         fall_tick,
   output logic         run,
   output logic         sel_hi,
   output logic         lrclk,
   output logic         frame_start
);

   localparam int unsigned CNT_W = BASE_LOG2 + 2;

   logic               run_q;
   logic               lr_q;
   logic               fs_q;
   logic               sel_hi_q;
   frame_ratio_e       ratio_q;
   logic [CNT_W-1:0]   cnt_q;
   logic [CNT_W:0]     ratio_len;
   logic               at_last;
   logic               at_mid;

   assign ratio_len = (CNT_W + 1)'(1) << (BASE_LOG2 + ratio_shift(ratio_q));
   assign at_last   = ({1'b0, cnt_q} == (ratio_len - 1'b1));
   assign at_mid    = ({1'b0, cnt_q} == ((ratio_len >> 1) - 1'b1));

   always_ff @(posedge mclk or negedge rst_n) begin
      if (!rst_n) begin
         run_q    <= 1'b0;
         lr_q     <= 1'b0;
         fs_q     <= 1'b0;
         sel_hi_q <= 1'b0;
         ratio_q  <= FR_BASE;
         cnt_q    <= '0;
      end else begin
         fs_q <= 1'b0;
         if (!run_q) begin
            lr_q  <= 1'b0;
            cnt_q <= '0;
            if (en) begin
               run_q    <= 1'b1;
               fs_q     <= 1'b1;
               sel_hi_q <= sel_hi_in;
               ratio_q  <= ratio_in;
            end
         end else if (fall_tick) begin
            if (at_last) begin
               cnt_q <= '0;
               lr_q  <= 1'b0;
               if (en) begin
                  fs_q     <= 1'b1;
                  sel_hi_q <= sel_hi_in;
                  ratio_q  <= ratio_in;
               end else begin
                  run_q <= 1'b0;
               end
            end else begin
               cnt_q <= cnt_q + 1'b1;
               if (at_mid) lr_q <= 1'b1;
            end
         end
      end
   end

   assign run         = run_q;
   assign sel_hi      = sel_hi_q;
   assign lrclk       = lr_q;
   assign frame_start = fs_q;

   // R9
   cfg_hold_chk: assert property (@(posedge mclk) disable iff (!rst_n)
      !fs_q |-> ($stable(sel_hi_q) && $stable(ratio_q)));

   // R8
   stop_only_at_end_chk: assert property (@(posedge mclk) disable iff (!rst_n)
      $fell(run_q) |-> ($past(at_last) && $past(fall_tick)));

endmodule

// File: rtl/i2s_clk_gen.sv
module i2s_clk_gen
   import i2s_clk_pkg::*;
#(
   parameter int unsigned SCLK_DIV_LO = 2,
   parameter int unsigned SCLK_DIV_HI = 4,
   parameter int unsigned LR_BASE_LOG2 = 5
) (
   input  logic       mclk,
   input  logic       rst_n,
   input  logic       en,
   input  logic       sclk_div4,
   input  logic [1:0] frame_ratio,
   output logic       sclk,
   output logic       lrclk,
   output logic       frame_start
);

   localparam int unsigned HALF_LO = SCLK_DIV_LO / 2;
   localparam int unsigned HALF_HI = SCLK_DIV_HI / 2;

   generate
      if (SCLK_DIV_LO < 2 || (SCLK_DIV_LO % 2) != 0 ||
          SCLK_DIV_HI < SCLK_DIV_LO || (SCLK_DIV_HI % 2) != 0) begin : g_bad_div
         $error("bit clock divisors must be even, at least 2, and ordered");
      end
      if (LR_BASE_LOG2 < 1 || LR_BASE_LOG2 > 12) begin : g_bad_ratio
         $error("word clock base ratio out of range");
      end
   endgenerate

   logic run;
   logic sel_hi;
   logic fall_tick;

   i2s_sclk_div #(
      .HALF_LO (HALF_LO),
      .HALF_HI (HALF_HI)
   ) u_bit (
      .mclk      (mclk),
      .rst_n     (rst_n),
      .run       (run),
      .sel_hi    (sel_hi),
      .sclk      (sclk),
      .fall_tick (fall_tick)
   );

   i2s_frame_div #(
      .BASE_LOG2 (LR_BASE_LOG2)
   ) u_frame (
      .mclk        (mclk),
      .rst_n       (rst_n),
      .en          (en),
      .sel_hi_in   (sclk_div4),
      .ratio_in    (frame_ratio_e'(frame_ratio)),
      .fall_tick   (fall_tick),
      .run         (run),
      .sel_hi      (sel_hi),
      .lrclk       (lrclk),
      .frame_start (frame_start)
   );

   // R5
   lr_on_fall_chk: assert property (@(posedge mclk) disable iff (!rst_n)
      !$stable(lrclk) |-> $fell(sclk));

   // R6
   fs_single_chk: assert property (@(posedge mclk) disable iff (!rst_n)
      frame_start |=> !frame_start);

   // R6
   fs_left_chk: assert property (@(posedge mclk) disable iff (!rst_n)
      frame_start |-> !lrclk);

   // R8
   park_low_chk: assert property (@(posedge mclk) disable iff (!rst_n)
      !run |-> (!sclk && !lrclk && !frame_start));

endmodule

// File: tb/tb_i2s_clk_gen.sv
module tb_i2s_clk_gen;

   logic       mclk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic       sclk_div4 = 1'b0;
   logic [1:0] frame_ratio = 2'b00;
   logic       sclk, lrclk, frame_start;

   int checks = 0;
   int errors = 0;

   always #10 mclk = ~mclk;

   i2s_clk_gen dut (
      .mclk        (mclk),
      .rst_n       (rst_n),
      .en          (en),
      .sclk_div4   (sclk_div4),
      .frame_ratio (frame_ratio),
      .sclk        (sclk),
      .lrclk       (lrclk),
      .frame_start (frame_start)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int half_of(input logic b);
      return b ? 2 : 1;
   endfunction

   function automatic int ratio_of(input logic [1:0] f);
      return (f == 2'b00) ? 32 : (f == 2'b01) ? 64 : 128;
   endfunction

   task automatic wait_fs();
      for (int i = 0; i < 3000; i++) begin
         @(negedge mclk);
         if (frame_start) return;
      end
   endtask

   // Called on the sample that shows frame_start; returns on the next one.
   task automatic count_frame(output int len, output int rises, output int highs,
                              output int viol, output int first_rise);
      logic ps, pl;
      ps = sclk; pl = lrclk;
      len = 1; rises = 0; highs = lrclk ? 1 : 0; viol = 0; first_rise = -1;
      for (int i = 0; i < 3000; i++) begin
         @(negedge mclk);
         if (frame_start) break;
         len++;
         if (sclk && !ps) begin
            rises++;
            if (first_rise < 0) first_rise = len - 1;
         end
         if (lrclk) highs++;
         if (lrclk != pl && !(ps && !sclk)) viol++;
         ps = sclk; pl = lrclk;
      end
   endtask

   task automatic check_frame(input int h, input int r, input string tag);
      int len, rises, highs, viol, fr;
      check(!lrclk, "R6 lrclk low at strobe", lrclk, 0);
      count_frame(len, rises, highs, viol, fr);
      check(len == 2*h*r, {tag, " frame length"}, len, 2*h*r);
      check(rises == r, "R2 sclk rises per frame", rises, r);
      check(fr == h, "R2 first sclk rise offset", fr, h);
      check(highs == h*r, {tag, " lrclk high half"}, highs, h*r);
      check(viol == 0, "R5 lrclk moved off sclk fall", viol, 0);
   endtask

   task automatic park();
      @(negedge mclk);
      en = 1'b0;
      repeat (600) @(negedge mclk);
   endtask

   task automatic t_reset();
      @(negedge mclk);
      check(!sclk && !lrclk && !frame_start, "R1 in reset", {sclk, lrclk, frame_start}, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge mclk);
      check(!sclk && !lrclk && !frame_start, "R1 after reset", {sclk, lrclk, frame_start}, 0);
   endtask

   task automatic t_run(input logic b, input logic [1:0] f, input string tag);
      park();
      sclk_div4 = b; frame_ratio = f; en = 1'b1;
      @(negedge mclk);
      check(frame_start && !sclk && !lrclk, "R7 strobe after enable",
            {frame_start, sclk, lrclk}, 3'b100);
      check_frame(half_of(b), ratio_of(f), tag);
      check(frame_start == 1'b1, "R6 next strobe", frame_start, 1);
      check_frame(half_of(b), ratio_of(f), tag);
   endtask

   task automatic t_reconfig();
      int len, rises, highs, viol, fr;
      park();
      sclk_div4 = 1'b0; frame_ratio = 2'b00; en = 1'b1;
      wait_fs();
      sclk_div4 = 1'b1; frame_ratio = 2'b01;
      count_frame(len, rises, highs, viol, fr);
      check(len == 64, "R9 current frame unchanged", len, 64);
      check(rises == 32, "R9 current frame bit count", rises, 32);
      count_frame(len, rises, highs, viol, fr);
      check(len == 256, "R9 next frame uses new ratios", len, 256);
      check(rises == 64, "R9 next frame bit count", rises, 64);
   endtask

   task automatic t_stop();
      int h, r, bad, rises;
      logic ps;
      h = 2; r = 32;
      park();
      sclk_div4 = 1'b1; frame_ratio = 2'b00; en = 1'b1;
      wait_fs();
      wait_fs();
      bad = 0; rises = 0; ps = sclk;
      for (int idx = 1; idx < 2*h*r + 600; idx++) begin
         @(negedge mclk);
         if (idx == 10) en = 1'b0;
         if (idx < 2*h*r) begin
            if (sclk && !ps) rises++;
            if (frame_start) bad++;
         end
         if (idx == 2*h*r - 1)
            check(lrclk == 1'b1, "R8 frame runs to its end", lrclk, 1);
         if (idx >= 2*h*r && (sclk || lrclk || frame_start)) bad++;
         ps = sclk;
      end
      check(rises == r, "R8 full bit count after stop request", rises, r);
      check(bad == 0, "R8 parked low after frame", bad, 0);
   endtask

   task automatic t_idle_fields();
      int bad;
      park();
      bad = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge mclk);
         sclk_div4 = i[0];
         frame_ratio = i[2:1];
         if (sclk || lrclk || frame_start) bad++;
      end
      check(bad == 0, "R10 idle ignores ratio inputs", bad, 0);
   endtask

   initial begin
      for (int c = 0; c < 150000; c++) @(posedge mclk);
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      t_reset();
      t_run(1'b0, 2'b00, "R3 div2 ratio32");
      t_run(1'b1, 2'b01, "R3 div4 ratio64");
      t_run(1'b0, 2'b10, "R3 div2 ratio128");
      t_run(1'b1, 2'b11, "R4 reserved code as 128");
      t_run(1'b1, 2'b00, "R3 div4 ratio32");
      t_reconfig();
      t_stop();
      t_idle_fields();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule